// File: doc/BRIEF.md
# GPIO and Control Register Bank

This block is a 16-bit register bank for a plain memory-mapped bus with separate read and write strobes. Most of its registers are plain storage: mode, clock divider, clock control, power, and three interrupt registers (request, mask, status). Each holds what software last wrote to it. The status register is a fixed read-only value. The power register has one side effect: writing bit 7 forces two further bits set.

The bank also contains a 16-line general-purpose I/O unit, built from a direction register, a level register and 16 input lines. A line marked as output drives the value of its level bit. The driven vector is refreshed only when software writes the direction register or the level register. On each refresh a one-cycle pulse flags every line whose driven value changed. An input line that changes copies its new value into its own level bit, whatever that line's direction.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register reads 0x0000 except status, and gpio_out and gpio_toggle are zero.
- R2: Only address bits [5:0] select a register, so higher address bits have no effect. The map is: 0x00 mode, 0x04 clock divider, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level, 0x28 level (second port).
- R3: A write stores bits [15:0] of bus_wdata and drops bits [31:16]. It takes effect at the clock edge that samples bus_wr. bus_rdata shows the addressed register in the same cycle as bus_rd, and is zero while bus_rd is low.
- R4: A power write stores the data. When data bit 7 is 1, the stored value is the data ORed with 0x8040.
- R5: Status always reads 0x0002, and writes to it are ignored.
- R6: A write to 0x24 or 0x28 stores the data ANDed with the current direction register into the level register. Both offsets read the level register, and 0x20 reads the direction register.
- R7: gpio_out equals level AND direction, recomputed from the new register values at the edge of each direction or level write. At any other time it holds its value.
- R8: gpio_toggle is high for exactly the cycle after a refresh, with a 1 for each line whose gpio_out value changed. In all other cycles it is zero.
- R9: When input line i changes, level bit i takes the new input value at the next edge, whatever the direction. If a bus level write falls in the same cycle, the input wins for that bit. An input change alone does not alter gpio_out.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data, low 16 bits used |
| bus_rdata | output | 16 | Read data |
| gpio_in | input | 16 | Input lines |
| gpio_out | output | 16 | Driven output lines |
| gpio_toggle | output | 16 | One-cycle changed-line pulse |

## Verification
Some properties are checked by assertions on every cycle:
- gpio_out never drives a line whose direction bit is clear, and it stays stable except after a refresh.
- gpio_toggle always equals the XOR of gpio_out with its previous value.
- A changed input lands in its level bit.
- A power write with bit 7 set leaves bits 15 and 6 set.
- Unmapped reads return zero.

Other behaviour only the bench scenarios can show:
- The full address map, and the truncation of write data.
- That the status register stays fixed.
- That writes to unmapped offsets leave every register untouched.
- That an input change stays invisible on gpio_out until a later direction or level write.
- That an input wins over a bus level write in the same cycle.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned OFS_W  = 6;

  // register slots; the stored ones come first
  localparam int unsigned IDX_MODE   = 0;
  localparam int unsigned IDX_CLKDIV = 1;
  localparam int unsigned IDX_PWR    = 2;
  localparam int unsigned IDX_CLKCTL = 3;
  localparam int unsigned IDX_IRQREQ = 4;
  localparam int unsigned IDX_IRQMSK = 5;
  localparam int unsigned IDX_IRQSTA = 6;
  localparam int unsigned NSTORE     = 7;
  localparam int unsigned IDX_STAT   = 7;
  localparam int unsigned IDX_DIR    = 8;
  localparam int unsigned IDX_LVLW   = 9;
  localparam int unsigned IDX_LVLR   = 10;
  localparam int unsigned NSEL       = 11;

  localparam logic [OFS_W-1:0] OFS_TAB [NSEL] = '{
    6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C,
    6'h08, 6'h20, 6'h24, 6'h28
  };

  localparam logic [REG_W-1:0] STAT_RST     = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE    = 16'h8040;
  localparam int unsigned      PWR_TRIG_BIT = 7;
endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
(
  input  logic [OFS_W-1:0] ofs_i,
  output logic [NSEL-1:0]  hit_o
);
  for (genvar g = 0; g < NSEL; g++) begin : g_hit
    assign hit_o[g] = (ofs_i == OFS_TAB[g]);
  end
endmodule

// File: rtl/gpio_rb_store.sv
module gpio_rb_store
  import gpio_rb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSTORE-1:0] wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  q_o [NSTORE]
);
  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    logic [REG_W-1:0] reg_d;
    logic [REG_W-1:0] reg_q;

    if (g == IDX_PWR) begin : g_pwr
      always_comb begin
        reg_d = wdata_i;
        if (wdata_i[PWR_TRIG_BIT]) reg_d = wdata_i | PWR_FORCE;
      end
    end else begin : g_plain
      always_comb reg_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       reg_q <= '0;
      else if (wr_i[g])  reg_q <= reg_d;
    end

    assign q_o[g] = reg_q;
  end

  assert_pwr_force_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i[IDX_PWR] && wdata_i[PWR_TRIG_BIT]) |=>
      (q_o[IDX_PWR][15] && q_o[IDX_PWR][6] && q_o[IDX_PWR][PWR_TRIG_BIT]));

  assert_pwr_plain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i[IDX_PWR] && !wdata_i[PWR_TRIG_BIT]) |=> (q_o[IDX_PWR] == $past(wdata_i)));
endmodule

// File: rtl/gpio_rb_pins.sv
module gpio_rb_pins #(
  parameter int unsigned N_LINES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_dir_i,
  input  logic               wr_lvl_i,
  input  logic [N_LINES-1:0] wdata_i,
  input  logic [N_LINES-1:0] pin_in_i,
  output logic [N_LINES-1:0] dir_o,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] pin_out_o,
  output logic [N_LINES-1:0] pin_tog_o
);
  logic [N_LINES-1:0] dir_q, dir_d;
  logic [N_LINES-1:0] lvl_q, lvl_d, lvl_bus;
  logic [N_LINES-1:0] in_q, in_chg;
  logic [N_LINES-1:0] drv_q, drv_d, drv_new;
  logic [N_LINES-1:0] tog_q, tog_d;
  logic               upd;

  // next-state
  always_comb begin
    upd     = wr_dir_i | wr_lvl_i;
    dir_d   = wr_dir_i ? wdata_i : dir_q;
    lvl_bus = wr_lvl_i ? (wdata_i & dir_q) : lvl_q;
    in_chg  = pin_in_i ^ in_q;
    lvl_d   = (lvl_bus & ~in_chg) | (pin_in_i & in_chg);
    drv_new = lvl_d & dir_d;
    drv_d   = upd ? drv_new : drv_q;
    tog_d   = upd ? (drv_new ^ drv_q) : '0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '0;
    else if (wr_dir_i) dir_q <= dir_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      in_q  <= '0;
      tog_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      in_q  <= pin_in_i;
      tog_q <= tog_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  drv_q <= '0;
    else if (upd) drv_q <= drv_d;
  end

  assign dir_o     = dir_q;
  assign lvl_o     = lvl_q;
  assign pin_out_o = drv_q;
  assign pin_tog_o = tog_q;

  assert_out_within_dir_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~dir_o) == '0);

  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_dir_i || wr_lvl_i) |=> $stable(pin_out_o));

  assert_toggle_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_tog_o == (pin_out_o ^ $past(pin_out_o)));

  assert_input_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_chg) |=> ((lvl_o & $past(in_chg)) == ($past(pin_in_i) & $past(in_chg))));

  assert_level_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lvl_i && in_chg == '0) |=> ((lvl_o & ~$past(dir_o)) == '0));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned N_GPIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_GPIO-1:0] gpio_in,
  output logic [N_GPIO-1:0] gpio_out,
  output logic [N_GPIO-1:0] gpio_toggle
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic               unused_bits;
  logic [REG_W-1:0]   wdata16;
  logic [NSEL-1:0]    hit;
  logic [NSTORE-1:0]  wr_vec;
  logic [REG_W-1:0]   store_q [NSTORE];
  logic [N_GPIO-1:0]  dir_q, lvl_q;
  logic [REG_W-1:0]   rd_val [NSEL];
  logic [REG_W-1:0]   rd_mux;

  assign unused_bits = ^{bus_wdata[BUS_W-1:REG_W], bus_addr[ADDR_W-1:OFS_W]};
  assign wdata16     = bus_wdata[REG_W-1:0];

  gpio_rb_decode i_decode (
    .ofs_i (bus_addr[OFS_W-1:0]),
    .hit_o (hit)
  );

  for (genvar g = 0; g < NSTORE; g++) begin : g_wr
    assign wr_vec[g] = bus_wr & hit[g];
  end

  gpio_rb_store i_store (
    .clk_i   (clk),
    .rst_ni  (rst_int_n),
    .wr_i    (wr_vec),
    .wdata_i (wdata16),
    .q_o     (store_q)
  );

  gpio_rb_pins #(.N_LINES(N_GPIO)) i_pins (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .wr_dir_i  (bus_wr & hit[IDX_DIR]),
    .wr_lvl_i  (bus_wr & (hit[IDX_LVLW] | hit[IDX_LVLR])),
    .wdata_i   (wdata16[N_GPIO-1:0]),
    .pin_in_i  (gpio_in),
    .dir_o     (dir_q),
    .lvl_o     (lvl_q),
    .pin_out_o (gpio_out),
    .pin_tog_o (gpio_toggle)
  );

  always_comb begin
    for (int i = 0; i < NSTORE; i++) rd_val[i] = store_q[i];
    rd_val[IDX_STAT] = STAT_RST;
    rd_val[IDX_DIR]  = REG_W'(dir_q);
    rd_val[IDX_LVLW] = REG_W'(lvl_q);
    rd_val[IDX_LVLR] = REG_W'(lvl_q);
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (hit[i]) rd_mux = rd_mux | rd_val[i];
    end
    bus_rdata = bus_rd ? rd_mux : '0;
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && hit == '0) |-> (bus_rdata == '0));

  assert_status_fixed_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && hit[IDX_STAT]) |-> (bus_rdata == 16'h0002));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_regbank.sv
`timescale 1ns/1ps
module test_gpio_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in, gpio_out, gpio_toggle;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic [15:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t sb_q [$];
  rd_item_t cur;

  always #2.5 clk = ~clk;

  gpio_regbank i_gpio_regbank (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .gpio_in, .gpio_out, .gpio_toggle
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard away from the edge
  always @(negedge clk) begin
    if (bus_rd && sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      chk({cur.tag, $sformatf(" read @0x%03h", cur.addr)}, bus_rdata, cur.exp);
    end
  end

  task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    it.addr = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  // pulse check: call right after wr returns
  task automatic chk_pulse(input string tag, input logic [15:0] exp_out, input logic [15:0] exp_tog);
    chk({tag, " out"}, gpio_out, exp_out);
    chk({tag, " toggle"}, gpio_toggle, exp_tog);
    @(posedge clk); #1;
    chk({tag, " toggle cleared"}, gpio_toggle, 16'h0000);
    chk({tag, " out held"}, gpio_out, exp_out);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; gpio_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset values, R5 status
    chk("R1 out at reset", gpio_out, 16'h0000);
    chk("R1 toggle at reset", gpio_toggle, 16'h0000);
    chk("R3 rdata idle", bus_rdata, 16'h0000);
    for (int i = 0; i <= 10; i++) begin
      rd(12'(i * 4), (i == 2) ? 16'h0002 : 16'h0000, (i == 2) ? "R5 status reset" : "R1 reset");
    end

    // R3 truncation, R2 upper address bits ignored
    wr(12'h000, 32'h1234_ABCD);
    rd(12'h000, 16'hABCD, "R3 mode truncated");
    wr(12'h104, 32'hFFFF_5A5A);
    rd(12'h004, 16'h5A5A, "R2 clkdiv via aliased address");
    rd(12'hF00, 16'hABCD, "R2 mode via high address");
    wr(12'h010, 32'h0000_00C3);
    wr(12'h014, 32'h0000_1111);
    wr(12'h018, 32'h0000_2222);
    wr(12'h01C, 32'h0000_3333);
    rd(12'h010, 16'h00C3, "R2 clkctl");
    rd(12'h014, 16'h1111, "R2 irq request");
    rd(12'h018, 16'h2222, "R2 irq mask");
    rd(12'h01C, 16'h3333, "R2 irq status");

    // R4 power
    wr(12'h00C, 32'h0000_0080);
    rd(12'h00C, 16'h80C0, "R4 power force");
    wr(12'h00C, 32'h0000_0001);
    rd(12'h00C, 16'h0001, "R4 power plain");

    // R5 status read-only
    wr(12'h008, 32'h0000_FFFF);
    rd(12'h008, 16'h0002, "R5 status after write");

    // R10 unmapped
    wr(12'h02C, 32'h0000_FFFF);
    wr(12'h03C, 32'h0000_FFFF);
    wr(12'h002, 32'h0000_FFFF);
    rd(12'h02C, 16'h0000, "R10 unmapped read");
    rd(12'h03C, 16'h0000, "R10 unmapped read");
    rd(12'h001, 16'h0000, "R10 unaligned read");
    rd(12'h000, 16'hABCD, "R10 mode untouched");
    rd(12'h020, 16'h0000, "R10 dir untouched");
    rd(12'h024, 16'h0000, "R10 level untouched");
    rd(12'h00C, 16'h0001, "R10 power untouched");

    // R6 R7 R8 gpio
    wr(12'h020, 32'h0000_00FF);
    chk_pulse("R7 dir write, level zero", 16'h0000, 16'h0000);
    wr(12'h024, 32'h0000_FFFF);
    chk_pulse("R8 level write", 16'h00FF, 16'h00FF);
    rd(12'h028, 16'h00FF, "R6 level masked by dir");
    rd(12'h020, 16'h00FF, "R6 dir read");
    wr(12'h020, 32'h0000_0F0F);
    chk_pulse("R7 dir shrink", 16'h000F, 16'h00F0);
    rd(12'h024, 16'h00FF, "R6 level kept on dir write");

    // R9 input on an input-direction line
    @(posedge clk); #1 gpio_in = 16'h8000;
    rd(12'h024, 16'h80FF, "R9 input sets level");
    chk("R9 out unchanged by input", gpio_out, 16'h000F);
    wr(12'h020, 32'h0000_8F0F);
    chk_pulse("R9 dir write exposes input", 16'h800F, 16'h8000);
    @(posedge clk); #1 gpio_in = 16'h8001;
    @(posedge clk); #1 gpio_in = 16'h8000;
    rd(12'h028, 16'h80FE, "R9 input clears level on output line");
    chk("R9 out waits for write", gpio_out, 16'h800F);
    wr(12'h028, 32'h0000_0001);
    chk_pulse("R6 write via 0x28", 16'h0001, 16'h800E);
    wr(12'h020, 32'h0000_FFFF);
    chk_pulse("R8 refresh no change", 16'h0001, 16'h0000);

    // R9 input wins over same-cycle level write
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 12'h024; bus_wdata = 32'h0;
    gpio_in = 16'h8004;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    chk_pulse("R9 input priority", 16'h0004, 16'h0005);
    rd(12'h024, 16'h0004, "R9 level after race");

    @(posedge clk); #1;
    if (sb_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule